// File: doc/BRIEF.md
# Processor Sleep Entry and Exit Sequencer

This block sits in the system logic next to one or more processors. It walks them from the clock-stopped grant state into the deep sleep state and back out. A sleep request first drives the active-low stop-clock pin. The block then waits until every processor reports that its stop-grant bus cycle has finished. After a fixed hold-off of bus clocks it drives the active-low sleep pin. The bus stays blocked through the entry window, through sleep itself, and through the exit window, because a snoop during those times gives undefined results.

A wake strobe ends sleep. The sleep pin is released first. If an interrupt is behind the wake, the stop-clock pin is released after a settle time, and the bus reopens one clock later. If only a snoop is behind the wake, the processors stay parked in the grant state with the bus open. A processor reset request overrides everything and returns all pins to their run values on the next clock.

Top module: `slpseq_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stpclk_n`=1, `slp_n`=1, `bus_block`=0 and `busy`=0.
- R2: `sleep_req` high in the idle state drives `stpclk_n` low on the next clock. `slp_n` stays 1 and `busy` stays 0 while any bit of `sg_done` is 0.
- R3: On the clock edge that first sees all bits of `sg_done` at 1, `busy` goes to 1. `slp_n` goes to 0 on the HOLD_CLKS-th edge after that edge, and not before.
- R4: `bus_block` goes to 1 on the same edge that `slp_n` goes to 0. While `slp_n` is 0, `stpclk_n` is 0 and `bus_block` is 1, and `bus_block` high always implies `busy` high.
- R5: `wake_evt` during the entry window (the first WIN_CLKS clocks after `slp_n` falls) has no effect: `slp_n` stays 0.
- R6: `wake_evt` after the entry window drives `slp_n` to 1 on the next edge. `stpclk_n` stays 0 and `bus_block` stays 1 at that point.
- R7: If `irq_pend` is 1 with the wake strobe, or at any time during the exit or settle windows, `stpclk_n` rises WIN_CLKS+SETTLE_CLKS edges after `slp_n` rises, with `bus_block` still 1. One edge later `bus_block` and `busy` fall.
- R8: Without an interrupt, WIN_CLKS+SETTLE_CLKS edges after `slp_n` rises, `bus_block` and `busy` fall while `stpclk_n` stays 0 (parked). While parked, `irq_pend` releases `stpclk_n` on the next edge, and `sleep_req` restarts the stop-grant wait.
- R9: `sleep_req` while `busy` is 1 is ignored. In particular it does not restart the hold-off count.
- R10: `cpu_rst_req` in any state makes `stpclk_n`=1, `slp_n`=1, `bus_block`=0 and `busy`=0 on the next edge. It wins over a simultaneous `wake_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| sg_done | input | NCPU | Per-processor stop-grant cycle finished (level) |
| sleep_req | input | 1 | Request to put the processors to sleep |
| wake_evt | input | 1 | One-clock strobe: a snoop or interrupt needs the processors |
| irq_pend | input | 1 | Interrupt pending flag that qualifies a wake |
| cpu_rst_req | input | 1 | Processor reset request |
| stpclk_n | output | 1 | Active-low stop-clock pin |
| slp_n | output | 1 | Active-low sleep pin |
| bus_block | output | 1 | Block new bus transactions and snoops |
| busy | output | 1 | Sequencer in a timed transition or asleep |

## Verification
The bench makes sleep wait while only part of `sg_done` is set. A design that reduced the vector with OR, or started on the first bit, would assert `slp_n` early. It checks `slp_n` one clock before and exactly at the end of the hold-off. It also sends a second `sleep_req` in the middle of the hold-off, which catches an off-by-one count or a count that restarts. Wake strobes inside the entry window must not raise `slp_n`. An exit that releases stop-clock together with the sleep pin, or reopens the bus in the same clock as stop-clock, fails the interrupt-wake checks. A snoop-only wake must leave stop-clock low. A reset request that arrives with a wake strobe must land in the run state, not in the exit window.

// File: rtl/slpseq_pkg.sv
package slpseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STOPGNT,
        ST_HOLDOFF,
        ST_ENTRY,
        ST_ASLEEP,
        ST_EXIT,
        ST_SETTLE,
        ST_RELEASE,
        ST_PARKED
    } seq_state_e;

    typedef struct packed {
        logic stpclk_n;
        logic slp_n;
        logic bus_block;
        logic busy;
    } pin_bundle_t;

    localparam pin_bundle_t PINS_RUN = '{stpclk_n: 1'b1, slp_n: 1'b1, bus_block: 1'b0, busy: 1'b0};

    function automatic pin_bundle_t pins_for(seq_state_e s);
        pin_bundle_t p;
        p = PINS_RUN;
        case (s)
            ST_IDLE:    p = PINS_RUN;
            ST_STOPGNT: p.stpclk_n = 1'b0;
            ST_PARKED:  p.stpclk_n = 1'b0;
            ST_HOLDOFF: begin
                p.stpclk_n = 1'b0;
                p.busy     = 1'b1;
            end
            ST_ENTRY, ST_ASLEEP: begin
                p.stpclk_n  = 1'b0;
                p.slp_n     = 1'b0;
                p.bus_block = 1'b1;
                p.busy      = 1'b1;
            end
            ST_EXIT, ST_SETTLE: begin
                p.stpclk_n  = 1'b0;
                p.bus_block = 1'b1;
                p.busy      = 1'b1;
            end
            ST_RELEASE: begin
                p.bus_block = 1'b1;
                p.busy      = 1'b1;
            end
            default: p = PINS_RUN;
        endcase
        return p;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/slpseq_timer.sv
module slpseq_timer #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/slpseq_fsm.sv
module slpseq_fsm
    import slpseq_pkg::*;
#(
    parameter int unsigned NCPU        = 2,
    parameter int unsigned HOLD_CLKS   = 100,
    parameter int unsigned WIN_CLKS    = 10,
    parameter int unsigned SETTLE_CLKS = 10,
    parameter int unsigned CW          = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCPU-1:0] sg_done,
    input  logic            sleep_req,
    input  logic            wake_evt,
    input  logic            irq_pend,
    input  logic            cpu_rst_req,
    input  logic [CW-1:0]   count,
    output logic            restart,
    output seq_state_e      state
);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CLKS - 1);
    localparam logic [CW-1:0] WIN_LAST    = CW'(WIN_CLKS - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CLKS - 1);

    seq_state_e next;
    logic       irq_seen;
    logic       all_granted;

    assign all_granted = &sg_done;

    always_comb begin
        next = state;
        case (state)
            ST_IDLE:    if (sleep_req) next = ST_STOPGNT;
            ST_STOPGNT: if (all_granted) next = ST_HOLDOFF;
            ST_HOLDOFF: if (count == HOLD_LAST) next = ST_ENTRY;
            ST_ENTRY:   if (count == WIN_LAST) next = ST_ASLEEP;
            ST_ASLEEP:  if (wake_evt) next = ST_EXIT;
            ST_EXIT:    if (count == WIN_LAST) next = ST_SETTLE;
            ST_SETTLE: begin
                if (count == SETTLE_LAST) begin
                    next = (irq_seen || irq_pend) ? ST_RELEASE : ST_PARKED;
                end
            end
            ST_RELEASE: next = ST_IDLE;
            ST_PARKED: begin
                if (irq_pend) begin
                    next = ST_IDLE;
                end else if (sleep_req) begin
                    next = ST_STOPGNT;
                end
            end
            default: next = ST_IDLE;
        endcase
        if (cpu_rst_req) begin
            next = ST_IDLE;
        end
    end

    assign restart = (next != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            irq_seen <= 1'b0;
        end else begin
            state <= next;
            if (state == ST_ASLEEP && wake_evt) begin
                irq_seen <= irq_pend;
            end else if (state == ST_EXIT || state == ST_SETTLE) begin
                irq_seen <= irq_seen | irq_pend;
            end else begin
                irq_seen <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/slpseq_pins.sv
module slpseq_pins
    import slpseq_pkg::*;
(
    input  seq_state_e  state,
    output pin_bundle_t pins
);
    assign pins = pins_for(state);
endmodule

// File: rtl/slpseq_top.sv
module slpseq_top
    import slpseq_pkg::*;
#(
    parameter int unsigned NCPU        = 2,
    parameter int unsigned HOLD_CLKS   = 100,
    parameter int unsigned WIN_CLKS    = 10,
    parameter int unsigned SETTLE_CLKS = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCPU-1:0] sg_done,
    input  logic            sleep_req,
    input  logic            wake_evt,
    input  logic            irq_pend,
    input  logic            cpu_rst_req,
    output logic            stpclk_n,
    output logic            slp_n,
    output logic            bus_block,
    output logic            busy
);
    localparam int unsigned LONGEST = max3(HOLD_CLKS, WIN_CLKS, SETTLE_CLKS);
    localparam int unsigned CW      = $clog2(LONGEST + 1);

    logic          restart;
    logic [CW-1:0] count;
    seq_state_e    state;
    pin_bundle_t   pins;

    slpseq_timer #(.CW(CW)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .count   (count)
    );

    slpseq_fsm #(
        .NCPU        (NCPU),
        .HOLD_CLKS   (HOLD_CLKS),
        .WIN_CLKS    (WIN_CLKS),
        .SETTLE_CLKS (SETTLE_CLKS),
        .CW          (CW)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .sg_done     (sg_done),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .irq_pend    (irq_pend),
        .cpu_rst_req (cpu_rst_req),
        .count       (count),
        .restart     (restart),
        .state       (state)
    );

    slpseq_pins pins_i (
        .state (state),
        .pins  (pins)
    );

    assign stpclk_n  = pins.stpclk_n;
    assign slp_n     = pins.slp_n;
    assign bus_block = pins.bus_block;
    assign busy      = pins.busy;
endmodule

// File: rtl/slpseq_chk.sv
module slpseq_chk (
    input logic clk,
    input logic rst,
    input logic cpu_rst_req,
    input logic stpclk_n,
    input logic slp_n,
    input logic bus_block,
    input logic busy
);
    // R4
    sleep_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !slp_n |-> !stpclk_n);

    // R4
    block_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        !slp_n |-> bus_block);

    // R4
    block_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
        bus_block |-> busy);

    // R3
    holdoff_before_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(slp_n) |-> $past(busy));

    // R6
    exit_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(slp_n) && !$past(cpu_rst_req)) |-> (bus_block && !stpclk_n));

    // R7
    reopen_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(stpclk_n) && bus_block) |=> (!bus_block && stpclk_n));

    // R10
    cpu_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_req |=> (stpclk_n && slp_n && !bus_block && !busy));
endmodule

bind slpseq_top slpseq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_rst_req (cpu_rst_req),
    .stpclk_n    (stpclk_n),
    .slp_n       (slp_n),
    .bus_block   (bus_block),
    .busy        (busy)
);

// File: tb/slpseq_top_test.sv
`timescale 1ns/1ps
module slpseq_top_test;
    localparam int NCPU = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCPU-1:0] sg_done = '0;
    logic            sleep_req = 1'b0;
    logic            wake_evt = 1'b0;
    logic            irq_pend = 1'b0;
    logic            cpu_rst_req = 1'b0;
    logic            stpclk_n, slp_n, bus_block, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slpseq_top #(.NCPU(NCPU), .HOLD_CLKS(100), .WIN_CLKS(10), .SETTLE_CLKS(10)) uut (
        .clk (clk), .rst (rst), .sg_done (sg_done), .sleep_req (sleep_req),
        .wake_evt (wake_evt), .irq_pend (irq_pend), .cpu_rst_req (cpu_rst_req),
        .stpclk_n (stpclk_n), .slp_n (slp_n), .bus_block (bus_block), .busy (busy)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pins(string req, logic e_stp, logic e_slp, logic e_blk, logic e_busy);
        checks++;
        if ({stpclk_n, slp_n, bus_block, busy} !== {e_stp, e_slp, e_blk, e_busy}) begin
            errors++;
            $display("FAIL %s: stpclk_n/slp_n/bus_block/busy actual %b%b%b%b expected %b%b%b%b",
                     req, stpclk_n, slp_n, bus_block, busy, e_stp, e_slp, e_blk, e_busy);
        end
    endtask

    // From idle: request sleep, partial grant, full grant, hold-off, entry.
    task automatic enter_sleep();
        sg_done = '0;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        expect_pins("R2", 1'b0, 1'b1, 1'b0, 1'b0);
        sg_done = 2'b01;
        tick(5);
        expect_pins("R2", 1'b0, 1'b1, 1'b0, 1'b0);
        sg_done = 2'b11;
        tick();
        expect_pins("R3", 1'b0, 1'b1, 1'b0, 1'b1);
        tick(99);
        expect_pins("R3", 1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        expect_pins("R4", 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    // Wake from sleep; irq selects release or park.
    task automatic wake_up(logic irq);
        irq_pend = irq;
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        irq_pend = 1'b0;
        expect_pins("R6", 1'b0, 1'b1, 1'b1, 1'b1);
        tick(19);
        expect_pins(irq ? "R7" : "R8", 1'b0, 1'b1, 1'b1, 1'b1);
        tick();
        if (irq) begin
            expect_pins("R7", 1'b1, 1'b1, 1'b1, 1'b1);
            tick();
            expect_pins("R7", 1'b1, 1'b1, 1'b0, 1'b0);
        end else begin
            expect_pins("R8", 1'b0, 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic test_reset();
        tick();
        expect_pins("R1", 1'b1, 1'b1, 1'b0, 1'b0);
        rst = 1'b0;
        tick();
        expect_pins("R1", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_entry_window_and_irq_wake();
        enter_sleep();
        tick(4);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        expect_pins("R5", 1'b0, 1'b0, 1'b1, 1'b1);
        tick(8);
        expect_pins("R5", 1'b0, 1'b0, 1'b1, 1'b1);
        wake_up(1'b1);
    endtask

    task automatic test_snoop_wake_then_resleep();
        enter_sleep();
        tick(10);
        wake_up(1'b0);
        tick(3);
        expect_pins("R8", 1'b0, 1'b1, 1'b0, 1'b0);
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        expect_pins("R8", 1'b0, 1'b1, 1'b0, 1'b0);
        tick();
        expect_pins("R8", 1'b0, 1'b1, 1'b0, 1'b1);
        tick(49);
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        tick(49);
        expect_pins("R9", 1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        expect_pins("R9", 1'b0, 1'b0, 1'b1, 1'b1);
        tick(10);
        wake_up(1'b0);
        irq_pend = 1'b1;
        tick();
        irq_pend = 1'b0;
        expect_pins("R8", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_cpu_reset_in_sleep();
        enter_sleep();
        tick(12);
        cpu_rst_req = 1'b1;
        wake_evt = 1'b1;
        tick();
        cpu_rst_req = 1'b0;
        wake_evt = 1'b0;
        expect_pins("R10", 1'b1, 1'b1, 1'b0, 1'b0);
        tick(3);
        expect_pins("R10", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        test_reset();
        test_entry_window_and_irq_wake();
        test_snoop_wake_then_resleep();
        test_cpu_reset_in_sleep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule